// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

The block is a binary up-counter built from identical narrow stages (four bits by default) that share a single rising clock edge. Every change of state is synchronous. An active-low clear forces the count to zero. An active-low parallel load copies a data word into the count. Two active-high count enables must both be high for the count to advance. The first, the parallel enable, is shared by every stage. The second, the chain enable, also gates each stage's terminal-count signal.

Each stage raises its terminal-count signal when its own value is all ones and its chain enable is high. That signal feeds the chain enable of the stage above it, so the stages behave as one wide binary counter. No stage is clocked from another. A modulo-N sequence can be built outside the block by decoding the count value N-1 and feeding it back, active-low, into the clear. The clear then acts on the following edge.

Top module: `cnt_chain`

## Requirements
- R1: The count changes only at a rising clock edge. A value on any control input shows on `count_out` only after the next rising edge.
- R2: If `clr_n` is 0 at a rising edge, the count becomes 0 at that edge, whatever the levels on `load_n`, `en_par` and `en_chain`.
- R3: If `clr_n` is 1 and `load_n` is 0 at a rising edge, the count takes the value of `data_in` at that edge, whatever the levels on both enables.
- R4: If `clr_n` and `load_n` are both 1 and `en_par` and `en_chain` are both 1, the full-width count increases by one at the edge.
- R5: If `clr_n` and `load_n` are both 1 and either enable is 0, the count holds its value.
- R6: Incrementing from all ones wraps the count to all zeros.
- R7: `carry_out` is high exactly when `en_chain` is 1 and the full count is all ones. It follows these inputs combinationally, and `en_par` has no effect on it.
- R8: Stage k+1 advances on the same edge at which stage k wraps, so a carry passes a stage boundary in one cycle (for example 0x0F counts to 0x10).
- R9: Feeding back the decode of count value N-1, active-low, into `clr_n` gives the repeating sequence 0, 1, ..., N-1, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| data_in | input | STAGES*STAGE_W | Value to load |
| en_par | input | 1 | Count enable shared by every stage; does not gate the carry |
| en_chain | input | 1 | Count enable of the lowest stage; also gates the carry |
| count_out | output | STAGES*STAGE_W | Current count |
| carry_out | output | 1 | Terminal count of the highest stage |

## Verification
Clear, load and increment can all be requested in the same cycle. The bench provokes this by starting from a loaded value and then applying all sixteen combinations of clear, load and the two enables. It judges each outcome against a priority model worked out in the bench: clear wins over load, and load wins over counting. It also puts a clear on top of a count that is about to wrap. It does this in the modulo-N run, where the clear is asserted at the decoded value while both enables are high, and the next value must be zero and not the incremented value.

// File: rtl/cnt_pkg.sv
// Shared types for the cascadable counter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cnt_pkg;

    // Action chosen for one stage at the next rising edge, listed by priority.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/cnt_ctrl.sv
// Control decode for one counter stage: chooses the edge action by strict
// priority (clear, load, count, hold) and forms the gated terminal count.
// Assumes: all control inputs are synchronous to the stage clock.
module cnt_ctrl
    import cnt_pkg::*;
#(
    parameter int STAGE_W = 4
) (
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_par,
    input  logic               en_trk,
    input  logic [STAGE_W-1:0] q,
    output cnt_act_e           act,
    output logic               tc
);

    localparam logic [STAGE_W-1:0] Q_MAX = '1;

    // Priority decode of the action for the coming edge.
    always_comb begin
        if (!clr_n)                act = ACT_CLEAR;
        else if (!load_n)          act = ACT_LOAD;
        else if (en_par && en_trk) act = ACT_COUNT;
        else                       act = ACT_HOLD;
    end

    // Terminal count: at maximum and enabled by the chain input only.
    always_comb begin
        tc = en_trk && (q == Q_MAX);
    end

endmodule

// File: rtl/cnt_stage.sv
// One counter stage: a STAGE_W-bit register updated by the action that
// cnt_ctrl selects, plus its terminal-count output for the next stage.
// Assumes: one clock; clr_n is the only reset and it is synchronous.
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int STAGE_W = 4
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_par,
    input  logic               en_trk,
    input  logic [STAGE_W-1:0] d,
    output logic [STAGE_W-1:0] q,
    output logic               tc
);

    cnt_act_e act;

    cnt_ctrl #(.STAGE_W(STAGE_W)) u_ctrl (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .q      (q),
        .act    (act),
        .tc     (tc)
    );

    // State register: applies the selected action at each rising edge.
    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR: q <= '0;
            ACT_LOAD:  q <= d;
            ACT_COUNT: q <= q + 1'b1;
            default:   q <= q;
        endcase
    end

    // R2: a sampled clear yields zero after the edge, whatever else is asserted.
    p_clear_zero_r2: assert property (@(posedge clk)
        !clr_n |=> (q == '0));

    // R3: load wins over both enables.
    p_load_value_r3: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(d)));

    // R4: both enables and no clear or load give an increment (R6 wrap included).
    p_step_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk) |=> (q == STAGE_W'($past(q) + 1'b1)));

    // R5: one enable low holds the value.
    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    // R7: the terminal count needs the chain enable.
    p_tc_gated_r7: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> en_trk);

endmodule

// File: rtl/cnt_chain.sv
// Cascadable counter top: STAGES copies of cnt_stage. Each stage's chain
// enable is the terminal count of the stage below it, so all stages count
// as one binary counter on a shared clock.
// Assumes: clr_n, load_n and en_par are common to every stage.
module cnt_chain #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic [STAGES*STAGE_W-1:0]   data_in,
    input  logic                        en_par,
    input  logic                        en_chain,
    output logic [STAGES*STAGE_W-1:0]   count_out,
    output logic                        carry_out
);

    localparam int TOTAL_W = STAGES * STAGE_W;

    logic [STAGES:0] link;

    // Chain input of the lowest stage comes from outside.
    always_comb begin
        link[0] = en_chain;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        cnt_stage #(.STAGE_W(STAGE_W)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_par (en_par),
            .en_trk (link[i]),
            .d      (data_in[i*STAGE_W +: STAGE_W]),
            .q      (count_out[i*STAGE_W +: STAGE_W]),
            .tc     (link[i+1])
        );
    end

    // Carry of the whole chain is the top stage's terminal count.
    always_comb begin
        carry_out = link[STAGES];
    end

    // R8: the full-width value steps by one when counting is enabled.
    p_chain_step_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_chain) |=>
            (count_out == TOTAL_W'($past(count_out) + 1'b1)));

    // R7: a chain carry implies the full count is at its maximum.
    p_carry_max_r7: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (&count_out && en_chain));

endmodule

// File: tb/tb_cnt_chain.sv
module tb_cnt_chain;

    localparam int CLK_P   = 10;
    localparam int STAGE_W = 4;
    localparam int STAGES  = 2;
    localparam int W       = STAGE_W * STAGES;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic [W-1:0] data_in = '0;
    logic         en_par = 1'b0;
    logic         en_chain = 1'b0;
    logic [W-1:0] count_out;
    logic         carry_out;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] exp_q;

    cnt_chain #(.STAGE_W(STAGE_W), .STAGES(STAGES)) dut (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .data_in   (data_in),
        .en_par    (en_par),
        .en_chain  (en_chain),
        .count_out (count_out),
        .carry_out (carry_out)
    );

    always #(CLK_P/2) clk = ~clk;

    // Priority model worked out from the requirements.
    function automatic logic [W-1:0] model(input logic [W-1:0] q, input logic c,
            input logic l, input logic p, input logic t, input logic [W-1:0] d);
        if (!c)          return '0;
        else if (!l)     return d;
        else if (p && t) return q + 1'b1;
        else             return q;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive controls at a falling edge, then wait to the next falling edge.
    task automatic step(input logic c, input logic l, input logic p, input logic t,
            input logic [W-1:0] d);
        clr_n = c; load_n = l; en_par = p; en_chain = t; data_in = d;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b0, 1'b1, 1'b0, 1'b0, '0);
        chk("R2 reset state", count_out, '0);
        chk("R7 reset carry", {{(W-1){1'b0}}, carry_out}, '0);

        // R3: every value loaded, with the enables swept alongside.
        for (int v = 0; v < (1 << W); v++) begin
            step(1'b1, 1'b0, v[0], v[1], W'(v));
            chk("R3 load", count_out, W'(v));
        end

        // R2/R3/R4/R5: all 16 control combinations from a known value.
        for (int k = 0; k < 16; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5);
            clr_n = k[3]; load_n = k[2]; en_par = k[1]; en_chain = k[0]; data_in = 8'h3C;
            // R1: nothing changes before the edge.
            #1;
            chk("R1 no change before edge", count_out, 8'hA5);
            @(negedge clk);
            chk("R2/R3/R4/R5 priority", count_out,
                model(8'hA5, k[3], k[2], k[1], k[0], 8'h3C));
        end

        // R8: carry crosses a stage boundary in one cycle.
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R8 boundary 0F->10", count_out, 8'h10);

        // R4/R6/R7/R8: full sweep with wraparound against a wide reference.
        step(1'b0, 1'b1, 1'b0, 1'b0, '0);
        exp_q = '0;
        clr_n = 1'b1; en_par = 1'b1; en_chain = 1'b1;
        for (int n = 0; n < (1 << W) + 4; n++) begin
            #1;
            chk("R7 carry while counting", {{(W-1){1'b0}}, carry_out},
                {{(W-1){1'b0}}, (exp_q == MAXV)});
            @(negedge clk);
            exp_q = exp_q + 1'b1;
            chk("R4/R6/R8 count", count_out, exp_q);
        end

        // R7: en_par has no effect on carry; en_chain gates it; R5 hold.
        step(1'b1, 1'b0, 1'b0, 1'b0, MAXV);
        clr_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_chain = 1'b1;
        #1;
        chk("R7 carry with en_par low", {{(W-1){1'b0}}, carry_out}, 8'h01);
        @(negedge clk);
        chk("R5 hold with en_par low", count_out, MAXV);
        en_chain = 1'b0; en_par = 1'b1;
        #1;
        chk("R7 carry with en_chain low", {{(W-1){1'b0}}, carry_out}, 8'h00);
        @(negedge clk);
        chk("R5 hold with en_chain low", count_out, MAXV);
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'hFE);
        en_par = 1'b0; en_chain = 1'b1; load_n = 1'b1;
        #1;
        chk("R7 no carry below max", {{(W-1){1'b0}}, carry_out}, 8'h00);
        @(negedge clk);

        // R9: modulo-10 through feedback of the decoded value 9 into clear.
        step(1'b0, 1'b1, 1'b1, 1'b1, '0);
        exp_q = '0;
        for (int n = 0; n < 30; n++) begin
            clr_n = (count_out != 8'd9);
            load_n = 1'b1; en_par = 1'b1; en_chain = 1'b1;
            @(negedge clk);
            exp_q = (exp_q == 8'd9) ? 8'd0 : exp_q + 1'b1;
            chk("R9 modulo-10", count_out, exp_q);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule